// File: doc/BRIEF.md
# Key-Guarded Countdown Watchdog with Deferred Register Commit

This block is a countdown watchdog that software programs through six word-aligned 32-bit registers. While enabled, a counter steps down by one per clock from a programmed reload value. If software fails to service it in time and the count reaches zero, the block raises a one-cycle reset request and starts the next period.

Writes that change the timer (reload value, enable, service) do not act at once. They go through a commit stage that models a slower timer domain. Software can poll busy flags to see that a commit is in progress. A sticky error flag records any timer write that arrived while a commit was still pending. A lock register guards the timer registers: only one 32-bit key opens them, and any other value closes them again.

The commit sequencer is a two-state machine. `ST_IDLE` moves to `ST_COMMIT` on an accepted timer write (transition "accept"). `ST_COMMIT` stays put while its cycle counter is above zero (transition "wait"). When the counter reaches zero, it returns to `ST_IDLE` and the pending value is applied (transition "apply").

Top module: `keyguard_wdt`

## Requirements
- R1: After reset, the lock reads 0 (unlocked), control reads 0, the reload value and current count both read 0xFFFFFFFF, status reads 0 and `wdog_rst_req` is low.
- R2: Word offsets are 0x00 reload value (read/write), 0x04 current count (read-only), 0x08 control (bit 0 = enable), 0x0C service (write-only, reads 0), 0x10 lock (reads bit 0 only), 0x14 status (bits 3:0). Unused bits read 0, and writes with `addr[1:0]` not 00 are ignored.
- R3: A timer write (offset 0x00, 0x08 or 0x0C) that is accepted at clock edge E takes effect at edge E+4. For the 4 cycles in between, status bit 0 reads 1. Bit 1 also reads 1 during a reload-value commit, and bit 2 during a control commit.
- R4: A committed reload-value write stores the value and restarts the current count from it.
- R5: While enabled, the count drops by one each cycle, except in a cycle where a commit takes effect. While disabled, the count holds.
- R6: When enabled with a count of 0, the block drives `wdog_rst_req` high for exactly one cycle and reloads the count, so an unserviced reload value N gives a pulse every N+1 cycles.
- R7: A committed service write reloads the count from the reload value. Servicing often enough prevents any reset request.
- R8: Writing 0x1ACCE551 to 0x10 unlocks (lock reads 0), and any other value locks (lock reads 1). Lock writes always act at the next edge.
- R9: While locked, timer writes are ignored. They cause no busy flag, no value change and no error.
- R10: A timer write that arrives while a commit is busy is dropped and sets status bit 3.
- R11: Status bit 3 stays set until a write to 0x14 with bit 3 = 1. A status write never starts a commit, and one with bit 3 = 0 leaves the flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe, sampled on the rising edge |
| addr | input | ADDR_W (5) | Byte address for reads and writes |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| wdog_rst_req | output | 1 | One-cycle reset request on expiry |

## Verification
The hardest state to reach is a second timer write landing inside an open commit window. The bench issues two back-to-back reload-value writes one cycle apart. It then checks that the error flag is set, that the first value wins, and that the flag survives a non-clearing status write. The boundary of the window matters too. The service loop spaces its writes exactly one cycle past the 4-cycle window, so an off-by-one in the busy span would show up as a spurious error or a missed reload before the count expires.

// File: rtl/kwd_pkg.sv
package kwd_pkg;
    localparam int DATA_W = 32;
    localparam logic [31:0] UNLOCK_KEY = 32'h1ACCE551;

    localparam int IDX_LOAD = 0;
    localparam int IDX_CUR  = 1;
    localparam int IDX_CTRL = 2;
    localparam int IDX_SVC  = 3;
    localparam int IDX_LOCK = 4;
    localparam int IDX_STAT = 5;

    localparam int STAT_ERR_BIT = 3;

    typedef enum logic [1:0] {
        CMT_LOAD = 2'd0,
        CMT_CTRL = 2'd1,
        CMT_SVC  = 2'd2
    } cmt_kind_e;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_COMMIT = 1'b1
    } cmt_state_e;
endpackage

// File: rtl/kwd_commit_fsm.sv
module kwd_commit_fsm
    import kwd_pkg::*;
#(
    parameter int COMMIT_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  cmt_kind_e         start_kind,
    input  logic [DATA_W-1:0] start_data,
    output logic              apply,
    output cmt_kind_e         apply_kind,
    output logic [DATA_W-1:0] apply_data,
    output logic              busy_any,
    output logic              busy_load,
    output logic              busy_ctrl
);
    localparam int CNT_W = (COMMIT_CYCLES > 1) ? $clog2(COMMIT_CYCLES) : 1;
    localparam int LEN_W = $clog2(COMMIT_CYCLES + 2);

    cmt_state_e        state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;
    cmt_kind_e         kind_q;
    logic [DATA_W-1:0] data_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = ST_COMMIT;
            ST_COMMIT: if (cnt_q == '0) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // pending write and cycle counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            kind_q <= CMT_LOAD;
            data_q <= '0;
        end else if (state_q == ST_IDLE && start) begin
            cnt_q  <= CNT_W'(COMMIT_CYCLES - 1);
            kind_q <= start_kind;
            data_q <= start_data;
        end else if (state_q == ST_COMMIT && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // outputs
    always_comb begin
        busy_any   = 1'b0;
        apply      = 1'b0;
        unique case (state_q)
            ST_IDLE:   busy_any = 1'b0;
            ST_COMMIT: begin
                busy_any = 1'b1;
                apply    = (cnt_q == '0);
            end
            default:   busy_any = 1'b0;
        endcase
        busy_load  = busy_any && (kind_q == CMT_LOAD);
        busy_ctrl  = busy_any && (kind_q == CMT_CTRL);
        apply_kind = kind_q;
        apply_data = data_q;
    end

    // busy window length, observed independently of the down-counter
    logic [LEN_W-1:0] busy_len_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        busy_len_q <= '0;
        else if (busy_any) busy_len_q <= busy_len_q + 1'b1;
        else               busy_len_q <= '0;
    end

    assert_busy_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy_any) |=> busy_any);
    assert_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
        apply |=> !busy_any);
    assert_window_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
        apply |-> (busy_len_q == LEN_W'(COMMIT_CYCLES - 1)));
    assert_kind_flags_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({busy_load, busy_ctrl}));
    assert_no_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
        busy_any |-> !start);
endmodule

// File: rtl/kwd_counter.sv
module kwd_counter
    import kwd_pkg::*;
#(
    parameter logic [DATA_W-1:0] RESET_LOAD = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              apply,
    input  cmt_kind_e         apply_kind,
    input  logic [DATA_W-1:0] apply_data,
    output logic [DATA_W-1:0] load_q,
    output logic [DATA_W-1:0] cur_q,
    output logic              en_q,
    output logic              rst_req
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            load_q  <= RESET_LOAD;
            cur_q   <= RESET_LOAD;
            en_q    <= 1'b0;
            rst_req <= 1'b0;
        end else begin
            rst_req <= 1'b0;
            if (apply) begin
                unique case (apply_kind)
                    CMT_LOAD: begin
                        load_q <= apply_data;
                        cur_q  <= apply_data;
                    end
                    CMT_CTRL: en_q  <= apply_data[0];
                    CMT_SVC:  cur_q <= load_q;
                    default:  ;
                endcase
            end else if (en_q) begin
                if (cur_q == '0) begin
                    rst_req <= 1'b1;
                    cur_q   <= load_q;
                end else begin
                    cur_q <= cur_q - 1'b1;
                end
            end
        end
    end

    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_q && !apply) |=> $stable(cur_q));
    assert_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q && !apply && cur_q != '0) |=> (cur_q == $past(cur_q) - 1'b1) && !rst_req);
    assert_expire_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q && !apply && cur_q == '0) |=> (rst_req && cur_q == $past(load_q)));
    assert_service_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (apply && apply_kind == CMT_SVC) |=> (cur_q == $past(load_q)));
endmodule

// File: rtl/kwd_regif.sv
module kwd_regif
    import kwd_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] load_q,
    input  logic [DATA_W-1:0] cur_q,
    input  logic              en_q,
    input  logic              busy_any,
    input  logic              busy_load,
    input  logic              busy_ctrl,
    output logic              start,
    output cmt_kind_e         start_kind,
    output logic              locked,
    output logic [DATA_W-1:0] rdata
);
    localparam int IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0] widx;
    logic aligned, hit_load, hit_cur, hit_ctrl, hit_svc, hit_lock, hit_stat;
    logic timer_wr, lock_wr, stat_wr;
    logic locked_q, err_q;

    assign widx     = addr[ADDR_W-1:2];
    assign aligned  = (addr[1:0] == 2'b00);
    assign hit_load = (widx == IDX_W'(IDX_LOAD));
    assign hit_cur  = (widx == IDX_W'(IDX_CUR));
    assign hit_ctrl = (widx == IDX_W'(IDX_CTRL));
    assign hit_svc  = (widx == IDX_W'(IDX_SVC));
    assign hit_lock = (widx == IDX_W'(IDX_LOCK));
    assign hit_stat = (widx == IDX_W'(IDX_STAT));

    assign timer_wr = wr_en && aligned && (hit_load || hit_ctrl || hit_svc);
    assign lock_wr  = wr_en && aligned && hit_lock;
    assign stat_wr  = wr_en && aligned && hit_stat;

    assign start      = timer_wr && !locked_q && !busy_any;
    assign start_kind = hit_ctrl ? CMT_CTRL : (hit_svc ? CMT_SVC : CMT_LOAD);
    assign locked     = locked_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       locked_q <= 1'b0;
        else if (lock_wr) locked_q <= (wdata != UNLOCK_KEY);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                 err_q <= 1'b0;
        else if (timer_wr && !locked_q && busy_any) err_q <= 1'b1;
        else if (stat_wr && wdata[STAT_ERR_BIT])    err_q <= 1'b0;
    end

    always_comb begin
        rdata = '0;
        if (aligned) begin
            if (hit_load)      rdata = load_q;
            else if (hit_cur)  rdata = cur_q;
            else if (hit_ctrl) rdata[0] = en_q;
            else if (hit_lock) rdata[0] = locked_q;
            else if (hit_stat) rdata[3:0] = {err_q, busy_ctrl, busy_load, busy_any};
        end
    end

    assert_err_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_q) |-> $past(busy_any));
    assert_locked_no_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (locked_q && timer_wr && !err_q) |=> !err_q);
    assert_key_opens_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_wr && wdata == UNLOCK_KEY) |=> !locked_q);
    assert_err_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (err_q && !(stat_wr && wdata[STAT_ERR_BIT])) |=> err_q);
endmodule

// File: rtl/keyguard_wdt.sv
module keyguard_wdt
    import kwd_pkg::*;
#(
    parameter int                ADDR_W        = 5,
    parameter int                COMMIT_CYCLES = 4,
    parameter logic [DATA_W-1:0] RESET_LOAD    = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              wdog_rst_req
);
    logic              start, apply, busy_any, busy_load, busy_ctrl, en_q, locked;
    cmt_kind_e         start_kind, apply_kind;
    logic [DATA_W-1:0] apply_data, load_q, cur_q;

    kwd_regif #(.ADDR_W(ADDR_W)) u_regif (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .load_q(load_q), .cur_q(cur_q), .en_q(en_q),
        .busy_any(busy_any), .busy_load(busy_load), .busy_ctrl(busy_ctrl),
        .start(start), .start_kind(start_kind), .locked(locked), .rdata(rdata)
    );

    kwd_commit_fsm #(.COMMIT_CYCLES(COMMIT_CYCLES)) u_commit (
        .clk(clk), .rst_n(rst_n), .start(start), .start_kind(start_kind),
        .start_data(wdata), .apply(apply), .apply_kind(apply_kind),
        .apply_data(apply_data), .busy_any(busy_any), .busy_load(busy_load),
        .busy_ctrl(busy_ctrl)
    );

    kwd_counter #(.RESET_LOAD(RESET_LOAD)) u_counter (
        .clk(clk), .rst_n(rst_n), .apply(apply), .apply_kind(apply_kind),
        .apply_data(apply_data), .load_q(load_q), .cur_q(cur_q), .en_q(en_q),
        .rst_req(wdog_rst_req)
    );

    assert_locked_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && locked && !busy_any) |=> !busy_any);
    assert_pulse_enabled_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wdog_rst_req |-> $past(en_q));
endmodule

// File: tb/keyguard_wdt_bench.sv
`timescale 1ns/1ps
module keyguard_wdt_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [4:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        wdog_rst_req;

    int vectors = 0;
    int miscompares = 0;
    int pulse_cnt = 0;
    bit done = 1'b0;
    bit pending = 1'b0;
    logic [31:0] q_exp[$];
    string       q_tag[$];

    localparam logic [4:0] A_LOAD = 5'h00, A_CUR = 5'h04, A_CTRL = 5'h08,
                           A_SVC = 5'h0C, A_LOCK = 5'h10, A_STAT = 5'h14;

    keyguard_wdt u_keyguard_wdt (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .wdog_rst_req(wdog_rst_req)
    );

    always #10 clk = ~clk;

    always @(negedge clk) if (rst_n && wdog_rst_req) pulse_cnt++;

    // monitor: pops expected reads and compares
    initial begin
        forever begin
            wait (pending);
            #1;
            vectors++;
            if (rdata !== q_exp[0]) begin
                miscompares++;
                $display("FAIL %s: rdata=%h expected %h", q_tag[0], rdata, q_exp[0]);
            end
            void'(q_exp.pop_front());
            void'(q_tag.pop_front());
            pending = 1'b0;
        end
    end

    task automatic check_read(input logic [4:0] a, input logic [31:0] e, input string tag);
        addr = a;
        q_exp.push_back(e);
        q_tag.push_back(tag);
        pending = 1'b1;
        wait (!pending);
    endtask

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] e);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s: actual=%h expected %h", tag, act, e);
        end
    endtask

    task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        vectors++;
        miscompares++;
        $display("FAIL watchdog: run did not complete, actual=hung expected=done");
        finish_run();
    end

    initial begin
        logic [31:0] c1, c2;
        int p0, n, m;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check_read(A_LOAD, 32'hFFFF_FFFF, "R1 reload value");
        check_read(A_CUR,  32'hFFFF_FFFF, "R1 current count");
        check_read(A_CTRL, 32'h0, "R1 control");
        check_read(A_LOCK, 32'h0, "R1 lock");
        check_read(A_STAT, 32'h0, "R1 status");
        chk(wdog_rst_req == 1'b0, "R1 reset request", {31'b0, wdog_rst_req}, 32'h0);

        // R3/R4 reload-value commit timing
        bus_write(A_LOAD, 32'd5);
        check_read(A_STAT, 32'h3, "R3 busy after accept");
        repeat (3) @(negedge clk);
        check_read(A_STAT, 32'h3, "R3 busy in last window cycle");
        @(negedge clk);
        check_read(A_STAT, 32'h0, "R3 idle after commit");
        check_read(A_LOAD, 32'd5, "R4 reload value");
        check_read(A_CUR,  32'd5, "R4 count restarted");

        // R3/R5 enable commit and countdown
        bus_write(A_CTRL, 32'h1);
        check_read(A_STAT, 32'h5, "R3 control busy");
        repeat (4) @(negedge clk);
        check_read(A_CTRL, 32'h1, "R2 control enable bit");
        check_read(A_CUR, 32'd5, "R5 no step on commit cycle");
        @(negedge clk);
        check_read(A_CUR, 32'd4, "R5 step 1");
        @(negedge clk);
        check_read(A_CUR, 32'd3, "R5 step 2");

        // R6 expiry period and pulse width
        n = 0;
        while (!wdog_rst_req && n < 200) begin @(negedge clk); n++; end
        chk(wdog_rst_req == 1'b1, "R6 first expiry", {31'b0, wdog_rst_req}, 32'h1);
        @(negedge clk);
        chk(wdog_rst_req == 1'b0, "R6 one-cycle pulse", {31'b0, wdog_rst_req}, 32'h0);
        m = 1;
        while (!wdog_rst_req && m < 200) begin @(negedge clk); m++; end
        chk(m == 6, "R6 period", m, 6);

        // R5 disabled count holds
        bus_write(A_CTRL, 32'h0);
        repeat (4) @(negedge clk);
        addr = A_CUR; #1 c1 = rdata;
        p0 = pulse_cnt;
        repeat (10) @(negedge clk);
        #1 c2 = rdata;
        chk(c1 == c2, "R5 hold while disabled", c2, c1);
        chk(pulse_cnt == p0, "R5 no pulse while disabled", pulse_cnt, p0);

        // R7 service keeps the timer alive
        bus_write(A_LOAD, 32'd12);
        repeat (4) @(negedge clk);
        check_read(A_CUR, 32'd12, "R4 count restarted at 12");
        bus_write(A_CTRL, 32'h1);
        repeat (4) @(negedge clk);
        p0 = pulse_cnt;
        for (int i = 0; i < 8; i++) begin
            bus_write(A_SVC, 32'hDEAD_BEEF);
            repeat (4) @(negedge clk);
            if (i == 0) check_read(A_CUR, 32'd12, "R7 service reloads count");
        end
        chk(pulse_cnt == p0, "R7 no expiry while serviced", pulse_cnt, p0);
        check_read(A_STAT, 32'h0, "R10 spaced writes raise no error");
        check_read(A_SVC, 32'h0, "R2 service reads zero");

        // R10/R11 write during busy
        bus_write(A_CTRL, 32'h0);
        repeat (4) @(negedge clk);
        bus_write(A_LOAD, 32'd7);
        bus_write(A_LOAD, 32'd9);
        check_read(A_STAT, 32'hB, "R10 error set while busy");
        repeat (3) @(negedge clk);
        check_read(A_LOAD, 32'd7, "R10 second write dropped");
        check_read(A_STAT, 32'h8, "R11 error sticky after commit");
        bus_write(A_STAT, 32'h7);
        check_read(A_STAT, 32'h8, "R11 write without bit 3 keeps flag");
        bus_write(A_STAT, 32'h8);
        check_read(A_STAT, 32'h0, "R11 flag cleared, no commit");

        // R8/R9 lock
        bus_write(A_LOCK, 32'h0);
        check_read(A_LOCK, 32'h1, "R8 locked by other value");
        bus_write(A_LOAD, 32'h33);
        check_read(A_STAT, 32'h0, "R9 locked write not busy");
        repeat (4) @(negedge clk);
        check_read(A_LOAD, 32'd7, "R9 locked reload unchanged");
        bus_write(A_CTRL, 32'h1);
        repeat (4) @(negedge clk);
        check_read(A_CTRL, 32'h0, "R9 locked control unchanged");
        check_read(A_STAT, 32'h0, "R9 no error while locked");
        bus_write(A_LOCK, 32'h1ACC_E551);
        check_read(A_LOCK, 32'h0, "R8 key unlocks");
        bus_write(A_LOAD, 32'h33);
        repeat (4) @(negedge clk);
        check_read(A_LOAD, 32'h33, "R8 write accepted after unlock");

        // R2 misaligned write ignored
        bus_write(5'h01, 32'h44);
        check_read(A_STAT, 32'h0, "R2 misaligned write not busy");
        repeat (4) @(negedge clk);
        check_read(A_LOAD, 32'h33, "R2 misaligned write ignored");

        finish_run();
    end
endmodule